// File: doc/BRIEF.md
# DMA Channel Interrupt Combiner

This block gathers the completion (terminal-count) and fault events of eight DMA channels into one interrupt line. Each channel raises a one-cycle pulse when its transfer finishes or fails; the block turns every pulse into a sticky status bit, one bit per channel per event kind. Software finds the cause by reading the status and acknowledges it by writing ones to a clear register.

Each channel has an enable bit for its completion interrupt and another for its fault interrupt. These bits come from the channel configuration logic. Only enabled status bits reach the shared line. A priority register names the lowest-numbered channel with an enabled pending event, because channel 0 ranks highest. This saves the handler a bit scan.

Top module: `dmaIrqAgg`

## Requirements
- R1: After reset every status bit is 0, `irqOut` is low and the priority register reads 0.
- R2: A pulse on `tcEvt[n]` sets completion status bit n in the next cycle. The bit stays set until it is cleared, whatever happens on the event lines later.
- R3: A write to offset 4 clears completion status bit n for every set bit n of `regWdata` (bit n maps to channel n). Zero bits in the written word leave their status bits unchanged.
- R4: Fault status behaves the same way. `errEvt[n]` sets fault bit n, and a write to offset 5 clears the fault bits written as one.
- R5: When an event and a clear for the same channel and kind land in the same cycle, the status bit ends up set.
- R6: `irqOut` is high exactly when some channel has completion status set with `tcMask` bit 1, or fault status set with `errMask` bit 1. A mask bit of 1 enables the interrupt. `irqOut` follows a mask change in the same cycle.
- R7: Reads of offset 0 (completion) and offset 1 (fault) return the raw status in bits 7:0 regardless of the masks. Upper bits read 0.
- R8: Reads of offset 2 (completion) and offset 3 (fault) return the status ANDed with the matching mask.
- R9: A read of offset 6 returns the priority register. Bit 3 is 1 when any enabled status bit is set, and bits 2:0 hold the lowest channel number with an enabled completion or fault bit. The register reads 0 when nothing enabled is pending.
- R10: Writes to offsets 0, 1, 2, 3, 6 and 7 change no status bit. Reads of offset 7 return 0.
- R11: The read path is combinational. `regRdata` reflects `regAddr` and the current state in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tcEvt | input | 8 | Per-channel completion pulses |
| errEvt | input | 8 | Per-channel fault pulses |
| tcMask | input | 8 | Per-channel completion interrupt enables |
| errMask | input | 8 | Per-channel fault interrupt enables |
| regAddr | input | 3 | Register offset |
| regWr | input | 1 | Write strobe |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data |
| irqOut | output | 1 | Combined interrupt |

## Verification
The key case is a new event on a channel arriving in the same cycle as a software clear of that channel's bit. The event must win, and the channels whose bits were written as one but saw no event must drop. The bench forces this directly, with a clear of all ones written while pulses hit selected channels. Random traffic also keeps hitting the case, because events and clears are drawn independently each cycle. A reference model in the bench judges every cycle by reading back the raw, masked and priority registers and comparing them with the model.

// File: rtl/dmaIrqPkg.sv
package dmaIrqPkg;

  // Register offsets; clear offsets are behaviourally fixed by R3/R4.
  localparam int OFF_TC_RAW  = 0;
  localparam int OFF_ERR_RAW = 1;
  localparam int OFF_TC_MSK  = 2;
  localparam int OFF_ERR_MSK = 3;
  localparam int OFF_TC_CLR  = 4;
  localparam int OFF_ERR_CLR = 5;
  localparam int OFF_PEND    = 6;

  typedef enum logic [2:0] {
    RD_TC_RAW  = 3'd0,
    RD_ERR_RAW = 3'd1,
    RD_TC_MSK  = 3'd2,
    RD_ERR_MSK = 3'd3,
    RD_PEND    = 3'd4,
    RD_NONE    = 3'd5
  } rdSel_e;

  typedef struct packed {
    logic   tcClr;
    logic   errClr;
    rdSel_e rdSel;
  } regStrb_t;

endpackage

// File: rtl/dmaIrqCtrl.sv
module dmaIrqCtrl
  import dmaIrqPkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  output regStrb_t          strb
);

  always_comb begin
    strb.tcClr  = regWr && (int'(regAddr) == OFF_TC_CLR);
    strb.errClr = regWr && (int'(regAddr) == OFF_ERR_CLR);
    case (int'(regAddr))
      OFF_TC_RAW:  strb.rdSel = RD_TC_RAW;
      OFF_ERR_RAW: strb.rdSel = RD_ERR_RAW;
      OFF_TC_MSK:  strb.rdSel = RD_TC_MSK;
      OFF_ERR_MSK: strb.rdSel = RD_ERR_MSK;
      OFF_PEND:    strb.rdSel = RD_PEND;
      default:     strb.rdSel = RD_NONE;
    endcase
  end

  // R3 R4: at most one clear strobe per cycle
  always_comb begin
    a_r3_one_clear: assert (!(strb.tcClr && strb.errClr));
  end

endmodule

// File: rtl/dmaIrqDatapath.sv
module dmaIrqDatapath
  import dmaIrqPkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] tcEvt,
  input  logic [NUM_CH-1:0] errEvt,
  input  logic [NUM_CH-1:0] tcMask,
  input  logic [NUM_CH-1:0] errMask,
  input  regStrb_t          strb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irqOut
);

  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0] tcStat, errStat;
  logic [NUM_CH-1:0] tcClrVec, errClrVec;
  logic [NUM_CH-1:0] tcMsk, errMsk, anyMsk;
  logic              pendValid;
  logic [IDX_W-1:0]  pendIdx;

  assign tcClrVec  = strb.tcClr  ? wdata[NUM_CH-1:0] : '0;
  assign errClrVec = strb.errClr ? wdata[NUM_CH-1:0] : '0;

  // Sticky status, event beats clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tcStat  <= '0;
      errStat <= '0;
    end else begin
      tcStat  <= (tcStat  & ~tcClrVec)  | tcEvt;
      errStat <= (errStat & ~errClrVec) | errEvt;
    end
  end

  assign tcMsk  = tcStat & tcMask;
  assign errMsk = errStat & errMask;
  assign anyMsk = tcMsk | errMsk;
  assign irqOut = |anyMsk;

  // Lowest channel number wins
  always_comb begin
    pendValid = 1'b0;
    pendIdx   = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (anyMsk[i]) begin
        pendValid = 1'b1;
        pendIdx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (strb.rdSel)
      RD_TC_RAW:  rdata[NUM_CH-1:0] = tcStat;
      RD_ERR_RAW: rdata[NUM_CH-1:0] = errStat;
      RD_TC_MSK:  rdata[NUM_CH-1:0] = tcMsk;
      RD_ERR_MSK: rdata[NUM_CH-1:0] = errMsk;
      RD_PEND:    rdata[IDX_W:0]    = {pendValid, pendIdx};
      default:    rdata = '0;
    endcase
  end

  // R2: without a clear strobe no completion bit falls
  a_r2_tc_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !strb.tcClr |=> ((tcStat & $past(tcStat)) == $past(tcStat)));

  // R4: without a clear strobe no fault bit falls
  a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !strb.errClr |=> ((errStat & $past(errStat)) == $past(errStat)));

  // R5: every pulsed channel is set next cycle, clear or not
  a_r5_evt_wins: assert property (@(posedge clk) disable iff (!rstN)
    (|tcEvt || |errEvt) |=> (((tcStat & $past(tcEvt)) == $past(tcEvt)) &&
                             ((errStat & $past(errEvt)) == $past(errEvt))));

  // R3: a clear with zero data and no events leaves status alone
  a_r3_zero_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tcClr && wdata[NUM_CH-1:0] == '0 && tcEvt == '0) |=> $stable(tcStat));

  // R9: reported channel is pending and no lower one is
  a_r9_priority: assert property (@(posedge clk) disable iff (!rstN)
    pendValid |-> (anyMsk[pendIdx] &&
      ((anyMsk & ((NUM_CH'(1) << pendIdx) - NUM_CH'(1))) == '0)));

  // R6: line high only with an enabled status bit
  a_r6_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((tcStat & tcMask) != '0 || (errStat & errMask) != '0));

endmodule

// File: rtl/dmaIrqAgg.sv
module dmaIrqAgg
  import dmaIrqPkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] tcEvt,
  input  logic [NUM_CH-1:0] errEvt,
  input  logic [NUM_CH-1:0] tcMask,
  input  logic [NUM_CH-1:0] errMask,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut
);

  regStrb_t strb;

  dmaIrqCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .regAddr (regAddr),
    .regWr   (regWr),
    .strb    (strb)
  );

  dmaIrqDatapath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .tcEvt   (tcEvt),
    .errEvt  (errEvt),
    .tcMask  (tcMask),
    .errMask (errMask),
    .strb    (strb),
    .wdata   (regWdata),
    .rdata   (regRdata),
    .irqOut  (irqOut)
  );

  // R1: reset leaves the line low next cycle
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> !irqOut);

endmodule

// File: tb/dmaIrqAgg_test.sv
module dmaIrqAgg_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  tcEvt = '0, errEvt = '0, tcMask = '0, errMask = '0;
  logic [2:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] mTc = '0, mErr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles++;

  dmaIrqAgg uut (
    .clk(clk), .rstN(rstN), .tcEvt(tcEvt), .errEvt(errEvt),
    .tcMask(tcMask), .errMask(errMask), .regAddr(regAddr),
    .regWr(regWr), .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut)
  );

  function automatic logic [31:0] pendWord(logic [7:0] t, logic [7:0] e);
    logic [7:0] a = t | e;
    for (int i = 0; i < 8; i++)
      if (a[i]) return {28'd0, 1'b1, 3'(i)};
    return '0;
  endfunction

  function automatic logic [31:0] expRead(logic [2:0] a);
    case (a)
      3'd0: return {24'd0, mTc};
      3'd1: return {24'd0, mErr};
      3'd2: return {24'd0, mTc & tcMask};
      3'd3: return {24'd0, mErr & errMask};
      3'd6: return pendWord(mTc & tcMask, mErr & errMask);
      default: return '0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check comb outputs, advance model at posedge
  task automatic cyc(string tag, logic [7:0] te, logic [7:0] ee, logic [7:0] tm,
                     logic [7:0] em, logic [2:0] a, logic w, logic [31:0] wd);
    logic [7:0] nTc, nErr;
    tcEvt = te; errEvt = ee; tcMask = tm; errMask = em;
    regAddr = a; regWr = w; regWdata = wd;
    #1;
    check({tag, " read"}, regRdata, expRead(a));
    check("R6 irq", {31'd0, irqOut},
          {31'd0, |((mTc & tm) | (mErr & em))});
    nTc  = (mTc  & ~((w && a == 3'd4) ? wd[7:0] : 8'd0)) | te;
    nErr = (mErr & ~((w && a == 3'd5) ? wd[7:0] : 8'd0)) | ee;
    @(posedge clk);
    mTc = nTc; mErr = nErr;
    @(negedge clk);
  endtask

  task automatic rd(string tag, logic [2:0] a);
    cyc(tag, 8'd0, 8'd0, tcMask, errMask, a, 1'b0, 32'd0);
  endtask

  initial begin
    while (cycles < MAX_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 irq", {31'd0, irqOut}, 32'd0);
    rd("R1 tc raw", 3'd0);
    rd("R1 pend", 3'd6);
    // R2 set and hold
    cyc("R2 set", 8'h05, 8'h00, 8'hFF, 8'hFF, 3'd0, 1'b0, 0);
    rd("R2 tc raw", 3'd0);
    cyc("R2 hold", 8'h00, 8'h00, 8'hFF, 8'hFF, 3'd0, 1'b0, 0);
    check("R2 held", regRdata, 32'h05);
    // R3 zero bits ignored, one bits clear
    cyc("R3 zero", 8'h00, 8'h00, 8'hFF, 8'hFF, 3'd4, 1'b1, 32'h0);
    rd("R3 after zero", 3'd0);
    cyc("R3 clr", 8'h00, 8'h00, 8'hFF, 8'hFF, 3'd4, 1'b1, 32'h1);
    rd("R3 after clr", 3'd0);
    check("R3 value", regRdata, 32'h04);
    // R4 fault path
    cyc("R4 set", 8'h00, 8'h82, 8'hFF, 8'hFF, 3'd1, 1'b0, 0);
    rd("R4 err raw", 3'd1);
    cyc("R4 clr", 8'h00, 8'h00, 8'hFF, 8'hFF, 3'd5, 1'b1, 32'h80);
    rd("R4 after clr", 3'd1);
    check("R4 value", regRdata, 32'h02);
    // R5 event and clear collide
    cyc("R5 hit", 8'h30, 8'h00, 8'hFF, 8'hFF, 3'd4, 1'b1, 32'hFF);
    rd("R5 tc raw", 3'd0);
    check("R5 value", regRdata, 32'h30);
    // R7 R8 R9 masks and priority
    cyc("R7 raw", 8'h00, 8'h00, 8'h20, 8'h00, 3'd0, 1'b0, 0);
    rd("R8 tc masked", 3'd2);
    rd("R9 pend", 3'd6);
    check("R9 value", regRdata, 32'h0D);
    cyc("R9 err", 8'h00, 8'h00, 8'h20, 8'h02, 3'd6, 1'b0, 0);
    rd("R9 err pend", 3'd6);
    check("R9 err value", regRdata, 32'h09);
    rd("R8 err masked", 3'd3);
    // R6 all masked off
    cyc("R6 masked", 8'h00, 8'h00, 8'h00, 8'h00, 3'd6, 1'b0, 0);
    // R10 writes elsewhere have no effect
    for (int a = 0; a < 8; a++)
      if (a != 4 && a != 5) cyc("R10 wr", 8'h00, 8'h00, 8'hFF, 8'hFF, 3'(a), 1'b1, 32'hFF);
    rd("R10 tc", 3'd0);
    check("R10 tc value", regRdata, 32'h30);
    rd("R10 err", 3'd1);
    check("R10 err value", regRdata, 32'h02);
    rd("R10 addr7", 3'd7);
    // Random traffic, R11 read each cycle
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] a = 3'($urandom_range(0, 7));
      logic w = ($urandom_range(0, 3) == 0);
      cyc("R11 rand", 8'($urandom) & 8'($urandom), 8'($urandom) & 8'($urandom) & 8'($urandom),
          8'($urandom), 8'($urandom), a, w, $urandom);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule